// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps calendar time in packed BCD: seconds, minutes, hours, day of month, month, two-digit year and weekday. It advances one second on each pulse of a one-second tick input while a run bit is set. A byte-wide register port with address, write data, write strobe, read strobe and read data gives software access to the time, a six-field alarm, a control byte, a status byte and an interrupt-enable byte. Each tick checks the alarm against the new time, and a single interrupt line reports periodic events and alarm matches.

Software reads the time through a shadow bank that is refreshed only by a capture command. A multi-byte read therefore sees one consistent instant even while the clock keeps counting. To set the time, software stops the clock, writes the fields, and starts it again. Status flags for the alarm and for power-up stay set until software writes a one to their bit. While the alarm flag is pending and enabled, the interrupt line keeps producing fresh rising edges, so an edge-sensitive receiver cannot miss it.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the readable time is seconds 00, minutes 00, hours 00, day 01, month 01, year 00, weekday 00. The control byte (address 0x0D) reads 0x00, the status byte (0x0E) reads 0x80 and irqOut is low.
- R2: Control bit 0 is the run enable. A tick advances the time by one second only while that bit is 1. Ticks have no effect while it is 0.
- R3: Writes to time addresses 0x00 (seconds) through 0x06 (weekday) load the live counter and its readable copy only while the clock is stopped. While the clock runs, such writes are ignored.
- R4: Writing control bit 6 as 1 copies all seven live fields into the readable time registers. Between such commands the readable registers hold their values while the clock counts. Bit 6 always reads back as 0.
- R5: Seconds and minutes count 00 to 59 in BCD and hours count 00 to 23. Each wrap carries into the next field.
- R6: The day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and in month 02 after 29 when the BCD year is divisible by 4 and after 28 otherwise. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R7: The weekday counts 0 to 6 and advances by one at every day wrap, independent of the month.
- R8: Status bit 1 mirrors the run bit. Status bits 2, 3, 4 and 5 report whether the most recent counted tick produced a second, minute, hour and day event; a minute event is a seconds wrap, and so on up.
- R9: Alarm fields sit at 0x07 (seconds) through 0x0C (year). When all six equal the time produced by a counted tick, status bit 6 is set, whether or not the alarm interrupt is enabled.
- R10: Writing 1 to status bit 6 or bit 7 clears that flag. Writing 0 leaves it unchanged. If an alarm match and a clearing write fall in the same cycle, the flag ends up set.
- R11: Interrupt-enable bits [1:0] select the periodic event: 0 every second, 1 every minute, 2 every hour, 3 every day. With bit 2 set, each counted tick that produces the selected event gives one one-cycle pulse on irqOut. With bit 2 clear, no periodic pulse is produced.
- R12: With interrupt-enable bit 3 set and the alarm flag set, irqOut pulses high for one cycle every REARM_GAP cycles until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| addr | input | ADDR_W | Register byte address |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; rdData is valid the following cycle |
| rdData | output | 8 | Registered read data |
| irqOut | output | 1 | Interrupt line, edge-significant |

## Verification
Two functions can land on the same clock edge: an alarm match raised by a tick, and a software write that clears the alarm flag. The bench creates this collision by asserting secTick together with a write of 0x40 to the status byte, on the very tick whose new time equals the programmed alarm. It then judges the result by reading the status byte, where bit 6 must still be set. A second look at the same behaviour comes from a property stating that the flag can drop only after a clearing write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W      = 8;
  localparam int TIME_FIELDS  = 7;
  localparam int ALARM_FIELDS = 6;

  // field 0 (sec) sits in the least significant byte
  typedef struct packed {
    logic [FIELD_W-1:0] wday;
    logic [FIELD_W-1:0] year;
    logic [FIELD_W-1:0] mon;
    logic [FIELD_W-1:0] day;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] sec;
  } calTime_t;

  typedef struct packed {
    logic day;
    logic hour;
    logic min;
    logic sec;
  } tmEvt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               run;
    logic               snap;
    logic               load;
    logic [2:0]         loadSel;
    logic [FIELD_W-1:0] loadVal;
  } tmCmd_t;

  localparam calTime_t TIME_RESET = 56'h00_00_01_01_00_00_00;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon, input logic [7:0] year);
    logic [6:0] yBin;
    yBin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    case (mon)
      8'h02:                      return (yBin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     secTick,
  input  tmCmd_t   cmd,
  output calTime_t live,
  output calTime_t liveNext,
  output calTime_t shadow,
  output tmEvt_t   evt,
  output logic     tickHit
);
  logic [TIME_FIELDS-1:0][FIELD_W-1:0] liveArr, shadowArr, nextArr;
  calTime_t nxt;
  logic secWrap, minWrap, hourWrap, dayWrap, monWrap;

  assign tickHit = cmd.run & secTick;
  assign live    = liveArr;
  assign shadow  = shadowArr;

  always_comb begin
    secWrap  = (live.sec == 8'h59);
    minWrap  = secWrap & (live.min == 8'h59);
    hourWrap = minWrap & (live.hour == 8'h23);
    dayWrap  = hourWrap & (live.day == monthLast(live.mon, live.year));
    monWrap  = dayWrap & (live.mon == 8'h12);

    nxt      = live;
    nxt.sec  = secWrap ? 8'h00 : bcdInc(live.sec);
    if (secWrap)  nxt.min  = (live.min == 8'h59) ? 8'h00 : bcdInc(live.min);
    if (minWrap)  nxt.hour = (live.hour == 8'h23) ? 8'h00 : bcdInc(live.hour);
    if (hourWrap) begin
      nxt.day  = dayWrap ? 8'h01 : bcdInc(live.day);
      nxt.wday = (live.wday == 8'h06) ? 8'h00 : live.wday + 8'h01;
    end
    if (dayWrap)  nxt.mon  = monWrap ? 8'h01 : bcdInc(live.mon);
    if (monWrap)  nxt.year = (live.year == 8'h99) ? 8'h00 : bcdInc(live.year);

    evt.sec  = 1'b1;
    evt.min  = secWrap;
    evt.hour = minWrap;
    evt.day  = hourWrap;
  end

  assign liveNext = nxt;
  assign nextArr  = nxt;

  for (genvar f = 0; f < TIME_FIELDS; f++) begin : gField
    logic               fieldLoad;
    logic [FIELD_W-1:0] liveF, shadowF;

    assign fieldLoad = cmd.load && (cmd.loadSel == 3'(f));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          liveF <= TIME_RESET[f*FIELD_W +: FIELD_W];
      else if (tickHit)   liveF <= nextArr[f];
      else if (fieldLoad) liveF <= cmd.loadVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          shadowF <= TIME_RESET[f*FIELD_W +: FIELD_W];
      else if (cmd.snap)  shadowF <= liveF;
      else if (fieldLoad) shadowF <= cmd.loadVal;
    end

    assign liveArr[f]   = liveF;
    assign shadowArr[f] = shadowF;
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int REARM_GAP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  input  calTime_t          shadow,
  input  calTime_t          liveNext,
  input  tmEvt_t            evt,
  input  logic              tickHit,
  output tmCmd_t            cmd,
  output logic [7:0]        rdData,
  output logic              irqOut,
  output logic              alarmFlag,
  output logic              runBit
);
  localparam int GAP_W = (REARM_GAP > 1) ? $clog2(REARM_GAP) : 1;
  localparam logic [ADDR_W-1:0] A_ALARM0 = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(15);

  logic [ALARM_FIELDS-1:0][FIELD_W-1:0] alarmQ;
  logic [TIME_FIELDS-1:0][FIELD_W-1:0]  shadowArr;
  logic [3:0]       irqEnQ;
  logic [3:0]       evtQ;
  logic             runQ, almQ, pwrQ, irqQ;
  logic [GAP_W-1:0] gapCnt;
  logic [7:0]       rdMux;
  logic             isTime, isAlarm, stWr, match, periodicHit, alarmReq, alarmFire;
  logic [2:0]       alarmIdx;
  logic [3:0]       evtVec;

  assign shadowArr = shadow;
  assign evtVec    = evt;
  assign isTime    = addr < A_ALARM0;
  assign isAlarm   = (addr >= A_ALARM0) && (addr < A_CTRL);
  assign alarmIdx  = 3'(addr - A_ALARM0);
  assign stWr      = wrEn && (addr == A_STAT);

  assign cmd.run     = runQ;
  assign cmd.snap    = wrEn && (addr == A_CTRL) && wrData[6];
  assign cmd.load    = wrEn && isTime && !runQ;
  assign cmd.loadSel = addr[2:0];
  assign cmd.loadVal = wrData;

  assign match       = tickHit && (liveNext[ALARM_FIELDS*FIELD_W-1:0] == alarmQ);
  assign periodicHit = tickHit && irqEnQ[2] && evtVec[irqEnQ[1:0]];
  assign alarmReq    = almQ && irqEnQ[3];
  assign alarmFire   = alarmReq && (gapCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      irqEnQ <= '0;
      alarmQ <= '0;
    end else if (wrEn) begin
      if (addr == A_CTRL)  runQ   <= wrData[0];
      if (addr == A_IRQEN) irqEnQ <= wrData[3:0];
      if (isAlarm)         alarmQ[alarmIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almQ <= 1'b0;
      pwrQ <= 1'b1;
      evtQ <= '0;
    end else begin
      if (tickHit) evtQ <= evtVec;
      // a match in the same cycle as a clearing write wins
      if (match)                 almQ <= 1'b1;
      else if (stWr && wrData[6]) almQ <= 1'b0;
      if (stWr && wrData[7])     pwrQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (!alarmReq)          gapCnt <= '0;
      else if (gapCnt == '0)  gapCnt <= GAP_W'(REARM_GAP - 1);
      else                    gapCnt <= gapCnt - 1'b1;
      irqQ <= periodicHit | alarmFire;
    end
  end

  always_comb begin
    rdMux = 8'h00;
    if (isTime)            rdMux = shadowArr[addr[2:0]];
    else if (isAlarm)      rdMux = alarmQ[alarmIdx];
    else if (addr == A_CTRL)  rdMux = {7'd0, runQ};
    else if (addr == A_STAT)  rdMux = {pwrQ, almQ, evtQ, runQ, 1'b0};
    else if (addr == A_IRQEN) rdMux = {4'd0, irqEnQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= 8'h00;
    else if (rdEn) rdData <= rdMux;
  end

  assign irqOut    = irqQ;
  assign alarmFlag = almQ;
  assign runBit    = runQ;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int REARM_GAP = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              irqOut
);
  tmCmd_t   cmd;
  calTime_t liveTime, liveNext, shadowTime;
  tmEvt_t   evt;
  logic     tickHit, alarmFlag, runBit;

  rtc_time uTime (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .cmd      (cmd),
    .live     (liveTime),
    .liveNext (liveNext),
    .shadow   (shadowTime),
    .evt      (evt),
    .tickHit  (tickHit)
  );

  rtc_ctrl #(.ADDR_W(ADDR_W), .REARM_GAP(REARM_GAP)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrData    (wrData),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .shadow    (shadowTime),
    .liveNext  (liveNext),
    .evt       (evt),
    .tickHit   (tickHit),
    .cmd       (cmd),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .alarmFlag (alarmFlag),
    .runBit    (runBit)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input calTime_t          liveTime,
  input logic              alarmFlag,
  input logic              runBit
);
  // R2: stopped clock with no time write keeps every live field
  a_r2_stopped_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !(wrEn && (addr < ADDR_W'(7)))) |=> $stable(liveTime));

  // R2: a counted tick always moves the time
  a_r2_tick_advances: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && secTick) |=> (liveTime != $past(liveTime)));

  // R5: seconds stay a legal BCD value below 60
  a_r5_sec_bcd: assert property (@(posedge clk) disable iff (!rstN)
    (liveTime.sec[3:0] <= 4'd9) && (liveTime.sec < 8'h60));

  // R6: month stays within 01..12
  a_r6_month_range: assert property (@(posedge clk) disable iff (!rstN)
    (liveTime.mon >= 8'h01) && (liveTime.mon <= 8'h12));

  // R9: the alarm flag drops only after a clearing write
  a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !(wrEn && (addr == ADDR_W'(14)) && wrData[6])) |=> alarmFlag);
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .secTick   (secTick),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .liveTime  (liveTime),
  .alarmFlag (alarmFlag),
  .runBit    (runBit)
);

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
  localparam int GAP = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       irqOut;

  always #2 clk = ~clk;

  rtc_calendar #(.ADDR_W(4), .REARM_GAP(GAP)) uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .irqOut(irqOut));

  int checks = 0;
  int fails = 0;
  int irqRises = 0;
  logic irqPrev = 1'b0;
  int mT[7];   // sec, min, hour, day, mon, year, wday (binary)
  int mEvt = 0;
  int runNow = 0;

  always @(negedge clk) begin
    if (irqOut && !irqPrev) irqRises++;
    irqPrev = irqOut;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bcd(input int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int dim(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    mEvt = 1;
    mT[0]++;
    if (mT[0] == 60) begin
      mT[0] = 0; mEvt |= 2; mT[1]++;
      if (mT[1] == 60) begin
        mT[1] = 0; mEvt |= 4; mT[2]++;
        if (mT[2] == 24) begin
          mT[2] = 0; mEvt |= 8; mT[6] = (mT[6] + 1) % 7; mT[3]++;
          if (mT[3] > dim(mT[4], mT[5])) begin
            mT[3] = 1; mT[4]++;
            if (mT[4] > 12) begin
              mT[4] = 1; mT[5] = (mT[5] + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 4'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = int'(rdData);
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1'b1;
    @(negedge clk); secTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic setT(input int s, input int mi, input int h, input int d,
                      input int mo, input int y, input int w);
    mT[0] = s; mT[1] = mi; mT[2] = h; mT[3] = d; mT[4] = mo; mT[5] = y; mT[6] = w;
  endtask

  task automatic loadModel();
    wr(13, 0);
    for (int f = 0; f < 7; f++) wr(f, bcd(mT[f]));
    wr(13, 1);
    runNow = 1;
  endtask

  task automatic checkTime(input string req);
    int v;
    wr(13, 8'h40 | runNow);
    for (int f = 0; f < 7; f++) begin
      rd(f, v);
      check($sformatf("%s field%0d", req, f), v, bcd(mT[f]));
    end
  endtask

  task automatic writeAlarm();
    for (int f = 0; f < 6; f++) wr(7 + f, bcd(mT[f]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v, hold;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irqOut", int'(irqOut), 0);
    setT(0, 0, 0, 1, 1, 0, 0);
    for (int f = 0; f < 7; f++) begin
      rd(f, v);
      check($sformatf("R1 time field%0d", f), v, bcd(mT[f]));
    end
    rd(13, v); check("R1 control", v, 8'h00);
    rd(14, v); check("R1 status", v, 8'h80);

    // R10: write 0 keeps, write 1 clears power-up flag
    wr(14, 8'h00); rd(14, v); check("R10 write zero keeps", v, 8'h80);
    wr(14, 8'h80); rd(14, v); check("R10 write one clears", v, 8'h00);

    // R2: stopped ticks ignored
    repeat (3) tick();
    checkTime("R2 stopped");
    wr(13, 1); runNow = 1;
    rd(14, v); check("R8 run mirror", v & 8'h02, 8'h02);
    repeat (5) begin tick(); modelTick(); end
    checkTime("R2 running");

    // R3: time write ignored while running, accepted while stopped
    wr(0, 8'h33);
    checkTime("R3 ignored while running");
    wr(13, 0); runNow = 0;
    wr(0, 8'h33); mT[0] = 33;
    checkTime("R3 loaded while stopped");
    rd(14, v); check("R8 run mirror off", v & 8'h02, 8'h00);

    // R4: snapshot holds until next capture
    wr(13, 1); runNow = 1;
    wr(13, 8'h41);
    hold = bcd(mT[0]);
    repeat (2) begin tick(); modelTick(); end
    rd(0, v); check("R4 readable holds", v, hold);
    checkTime("R4 recapture");
    rd(13, v); check("R4 capture bit reads zero", v, 8'h01);

    // R5/R6/R7/R8 directed rollovers
    setT(59, 59, 23, 28, 2, 24, 6); loadModel(); tick(); modelTick();
    checkTime("R6 leap february to 29 R7 weekday wrap");
    setT(59, 59, 23, 28, 2, 23, 2); loadModel(); tick(); modelTick();
    checkTime("R6 common february to march");
    setT(59, 59, 23, 30, 4, 50, 3); loadModel(); tick(); modelTick();
    checkTime("R6 thirty day month");
    setT(59, 59, 23, 31, 12, 99, 5); loadModel(); tick(); modelTick();
    checkTime("R6 year wrap R5 carries");
    rd(14, v); check("R8 all events", v & 8'h3E, 8'h3E);
    tick(); modelTick();
    rd(14, v); check("R8 second only", v & 8'h3E, 8'h06);

    // R11 periodic interrupt per select
    for (int sel = 0; sel < 4; sel++) begin
      setT(58, 59, 23, 15, 6, 10, 3); loadModel();
      wr(15, 4 | sel);
      irqRises = 0;
      tick(); modelTick(); tick(); modelTick();
      repeat (3) @(negedge clk);
      check($sformatf("R11 periodic select %0d", sel), irqRises, (sel == 0) ? 2 : 1);
    end
    wr(15, 0); irqRises = 0;
    tick(); modelTick(); repeat (3) @(negedge clk);
    check("R11 periodic disabled", irqRises, 0);

    // R9 alarm sets flag without enable; R12 repeated pulses
    setT(10, 20, 5, 3, 3, 30, 2); loadModel();
    modelTick(); writeAlarm();
    irqRises = 0;
    tick();
    rd(14, v); check("R9 alarm flag", (v >> 6) & 1, 1);
    check("R9 no irq when disabled", irqRises, 0);
    wr(15, 8); irqRises = 0;
    repeat (4 * GAP) @(negedge clk);
    check("R12 repeated alarm pulses", int'(irqRises >= 3), 1);
    wr(14, 8'h40);
    repeat (4) @(negedge clk);
    irqRises = 0;
    repeat (4 * GAP) @(negedge clk);
    check("R12 quiet after clear", irqRises, 0);
    rd(14, v); check("R10 alarm cleared", (v >> 6) & 1, 0);

    // R10 collision: match and clear on the same edge
    wr(15, 0);
    setT(0, 0, 0, 1, 1, 0, 0); loadModel();
    modelTick(); writeAlarm();
    @(negedge clk);
    secTick = 1'b1; addr = 4'd14; wrData = 8'h40; wrEn = 1'b1;
    @(negedge clk);
    secTick = 1'b0; wrEn = 1'b0;
    rd(14, v); check("R10 set wins over clear", (v >> 6) & 1, 1);
    checkTime("R9 collision time");

    // Random calendars around rollovers (R5 R6 R7 R8)
    for (int i = 0; i < 25; i++) begin
      int n;
      mT[5] = int'($urandom_range(0, 99));
      mT[4] = int'($urandom_range(1, 12));
      mT[3] = dim(mT[4], mT[5]) - int'($urandom_range(0, 1));
      mT[2] = ($urandom_range(0, 1) == 1) ? 23 : int'($urandom_range(0, 23));
      mT[1] = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
      mT[0] = ($urandom_range(0, 1) == 1) ? 59 : int'($urandom_range(0, 59));
      mT[6] = int'($urandom_range(0, 6));
      loadModel();
      n = int'($urandom_range(1, 3));
      for (int k = 0; k < n; k++) begin tick(); modelTick(); end
      checkTime($sformatf("R5 R6 R7 random %0d", i));
      rd(14, v);
      check($sformatf("R8 random events %0d", i), (v >> 2) & 15, mEvt);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule